// File: doc/BRIEF.md
# Ring interrupt notify controller

This block collects completion and overflow events for a set of DMA ring hops and turns them into a single level interrupt. Each hop has three event sources: transmit done, receive done and receive overflow. A one-cycle pulse on any source sets a sticky bit in a packed notify vector. The three groups sit back to back in that vector, transmit first, then receive, then receive overflow. The vector is sliced into 32-bit words that software reads over a simple address and strobe port. Reading a notify word returns its contents and clears it in the same cycle.

A separate read/write enable vector holds one receive and one transmit enable bit per hop. The receive enable also gates the overflow bit of the same hop. The interrupt is raised when the block is armed and some notify bit has its enable set. Once raised, it stays high until software has read every notify word since the interrupt rose, including words that only hold disabled rings. The block then re-arms. A read-only register reports the number of hops.

Top module: `ring_irq_notify`

## Requirements
- R1: Packing: a pulse on ev_tx[h] sets notify bit h, ev_rx[h] sets bit HOPS+h, and ev_ovf[h] sets bit 2*HOPS+h. Notify word k holds notify bits 32k to 32k+31, with the lowest bit at bit 0, and it is read at address NOTIFY_BASE+k.
- R2: There are (31+3*HOPS)/32 notify words. Bits above 3*HOPS in the last word read as zero, and reads inside the notify region past the last word return zero.
- R3: A read of a notify word returns its value in reg_rdata on the cycle after the strobe and clears the word, so an immediate second read returns zero.
- R4: An event that arrives in the same cycle as a read of its word is not lost. The read returns the old value and the bit remains set afterwards.
- R5: There are (31+2*HOPS)/32 enable words, starting at ENABLE_BASE. Enable bit h is the receive enable of hop h and bit HOPS+h is its transmit enable. Bits above 2*HOPS read as zero and ignore writes.
- R6: Reading HOPCNT_ADDR returns HOPS in bits 10:0 and zero above them.
- R7: When armed, irq rises one cycle after an enabled notify bit becomes set.
- R8: A notify bit whose enable is clear never raises irq. Overflow bits are gated by the receive enable of their hop.
- R9: Once high, irq stays high until every notify word has been read at least once since it rose. It falls on the clock edge that takes the last such read.
- R10: After reset the notify bits, the enable bits and irq are all zero.
- R11: If an enabled notify bit is still set when the block re-arms, irq rises again on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_tx | input | HOPS | Transmit-done pulses, one per hop |
| ev_rx | input | HOPS | Receive-done pulses, one per hop |
| ev_ovf | input | HOPS | Receive-overflow pulses, one per hop |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its defaults: twelve hops, a 4-bit address, notify words at 0, enable words at 8 and the hop count at 12. Twelve hops give two notify words. The overflow group straddles the word boundary, and the second word is only four bits full, so the zero padding and the rule that even a word with no enabled ring must be read before re-arming are both exercised. The single enable word leaves eight unused bits on which write masking can be checked.

// File: rtl/ring_irq_pkg.sv
package ring_irq_pkg;
   localparam int unsigned WORD_W   = 32;
   localparam int unsigned HOPCNT_W = 11;

   function automatic int unsigned words_for(input int unsigned nbits);
      return (nbits + WORD_W - 1) / WORD_W;
   endfunction
endpackage

// File: rtl/rin_notify_bank.sv
module rin_notify_bank
   import ring_irq_pkg::*;
#(
   parameter int unsigned HOPS = 12,
   parameter int unsigned NW   = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [HOPS-1:0]     ev_tx,
   input  logic [HOPS-1:0]     ev_rx,
   input  logic [HOPS-1:0]     ev_ovf,
   input  logic [NW-1:0]       rd_hit,
   output logic [NW*WORD_W-1:0] note_pad
);
   localparam int unsigned NBITS = 3 * HOPS;
   localparam int unsigned PAD_W = NW * WORD_W;

   logic [NBITS-1:0] set_vec;
   logic [NBITS-1:0] bits_q;

   assign set_vec = {ev_ovf, ev_rx, ev_tx};

   for (genvar i = 0; i < NBITS; i++) begin : g_bit
      localparam int unsigned WI = i / WORD_W;
      always_ff @(posedge clk) begin
         if (!rst_n) bits_q[i] <= 1'b0;
         else        bits_q[i] <= set_vec[i] | (bits_q[i] & ~rd_hit[WI]);
      end
   end

   assign note_pad = PAD_W'(bits_q);
endmodule

// File: rtl/rin_enable_regs.sv
module rin_enable_regs
   import ring_irq_pkg::*;
#(
   parameter int unsigned HOPS = 12,
   parameter int unsigned EW   = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [EW-1:0]        wr_hit,
   input  logic [WORD_W-1:0]    wdata,
   output logic [EW*WORD_W-1:0] en_pad
);
   localparam int unsigned NBITS = 2 * HOPS;
   localparam int unsigned PAD_W = EW * WORD_W;

   logic [NBITS-1:0] en_q;
   logic             unused_wdata;

   assign unused_wdata = ^wdata;

   for (genvar i = 0; i < NBITS; i++) begin : g_en
      localparam int unsigned WI = i / WORD_W;
      localparam int unsigned BI = i % WORD_W;
      always_ff @(posedge clk) begin
         if (!rst_n)          en_q[i] <= 1'b0;
         else if (wr_hit[WI]) en_q[i] <= wdata[BI];
      end
   end

   assign en_pad = PAD_W'(en_q);
endmodule

// File: rtl/rin_rearm.sv
module rin_rearm #(
   parameter int unsigned NW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pending,
   input  logic [NW-1:0] rd_hit,
   output logic          irq
);
   logic [NW-1:0] seen_q;
   logic [NW-1:0] seen_nxt;
   logic          irq_q;

   assign seen_nxt = seen_q | rd_hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_q  <= 1'b0;
         seen_q <= '0;
      end else if (!irq_q) begin
         if (pending) begin
            irq_q  <= 1'b1;
            seen_q <= '0;
         end
      end else if (&seen_nxt) begin
         irq_q  <= 1'b0;
         seen_q <= '0;
      end else begin
         seen_q <= seen_nxt;
      end
   end

   assign irq = irq_q;
endmodule

// File: rtl/ring_irq_notify.sv
module ring_irq_notify
   import ring_irq_pkg::*;
#(
   parameter int unsigned HOPS        = 12,
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned NOTIFY_BASE = 0,
   parameter int unsigned ENABLE_BASE = 8,
   parameter int unsigned HOPCNT_ADDR = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [HOPS-1:0]   ev_tx,
   input  logic [HOPS-1:0]   ev_rx,
   input  logic [HOPS-1:0]   ev_ovf,
   input  logic              reg_rd,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              irq
);
   localparam int unsigned NOTE_WORDS = words_for(3 * HOPS);
   localparam int unsigned EN_WORDS   = words_for(2 * HOPS);

   if (HOPS < 1 || HOPS >= (1 << HOPCNT_W))
      $error("HOPS must fit the hop count field");
   if (NOTIFY_BASE + NOTE_WORDS > ENABLE_BASE)
      $error("notify region overlaps enable region");
   if (ENABLE_BASE + EN_WORDS > HOPCNT_ADDR)
      $error("enable region overlaps hop count register");
   if (HOPCNT_ADDR >= (1 << ADDR_W))
      $error("address width too small for register map");

   logic [NOTE_WORDS-1:0]        rd_note_hit;
   logic [EN_WORDS-1:0]          wr_en_hit;
   logic [NOTE_WORDS*WORD_W-1:0] note_pad;
   logic [EN_WORDS*WORD_W-1:0]   en_pad;
   logic [WORD_W-1:0]            rd_word;
   logic [WORD_W-1:0]            rdata_q;
   logic                         pending;

   for (genvar k = 0; k < NOTE_WORDS; k++) begin : g_ndec
      assign rd_note_hit[k] = reg_rd && (reg_addr == ADDR_W'(NOTIFY_BASE + k));
   end
   for (genvar k = 0; k < EN_WORDS; k++) begin : g_edec
      assign wr_en_hit[k] = reg_wr && (reg_addr == ADDR_W'(ENABLE_BASE + k));
   end

   rin_notify_bank #(.HOPS(HOPS), .NW(NOTE_WORDS)) u_bank (
      .clk(clk), .rst_n(rst_n), .ev_tx(ev_tx), .ev_rx(ev_rx), .ev_ovf(ev_ovf),
      .rd_hit(rd_note_hit), .note_pad(note_pad)
   );

   rin_enable_regs #(.HOPS(HOPS), .EW(EN_WORDS)) u_en (
      .clk(clk), .rst_n(rst_n), .wr_hit(wr_en_hit), .wdata(reg_wdata),
      .en_pad(en_pad)
   );

   // transmit bits use the transmit enables; receive and overflow use receive
   assign pending = |(note_pad[0 +: HOPS]      & en_pad[HOPS +: HOPS])
                  | |(note_pad[HOPS +: HOPS]   & en_pad[0 +: HOPS])
                  | |(note_pad[2*HOPS +: HOPS] & en_pad[0 +: HOPS]);

   rin_rearm #(.NW(NOTE_WORDS)) u_arm (
      .clk(clk), .rst_n(rst_n), .pending(pending), .rd_hit(rd_note_hit),
      .irq(irq)
   );

   always_comb begin
      rd_word = '0;
      for (int k = 0; k < NOTE_WORDS; k++)
         if (reg_addr == ADDR_W'(NOTIFY_BASE + k)) rd_word = note_pad[k*WORD_W +: WORD_W];
      for (int k = 0; k < EN_WORDS; k++)
         if (reg_addr == ADDR_W'(ENABLE_BASE + k)) rd_word = en_pad[k*WORD_W +: WORD_W];
      if (reg_addr == ADDR_W'(HOPCNT_ADDR))
         rd_word = WORD_W'(HOPCNT_W'(HOPS));
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      rdata_q <= '0;
      else if (reg_rd) rdata_q <= rd_word;
   end

   assign reg_rdata = rdata_q;
endmodule

// File: rtl/ring_irq_notify_chk.sv
module ring_irq_notify_chk #(
   parameter int unsigned HOPS        = 12,
   parameter int unsigned NW          = 2,
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned NOTIFY_BASE = 0,
   parameter int unsigned HOPCNT_ADDR = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic [HOPS-1:0]   ev_tx,
   input logic [HOPS-1:0]   ev_rx,
   input logic [HOPS-1:0]   ev_ovf,
   input logic              reg_rd,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [31:0]       reg_rdata,
   input logic              irq,
   input logic [NW*32-1:0]  note_pad
);
   p_event_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ev_tx[0] |=> note_pad[0]);

   p_read_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == ADDR_W'(NOTIFY_BASE) && ev_tx == '0 && ev_rx == '0
       && ev_ovf == '0) |=> note_pad[31:0] == 32'h0);

   p_hopcnt_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == ADDR_W'(HOPCNT_ADDR)) |=> reg_rdata == 32'(HOPS));

   p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(|note_pad));

   p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !reg_rd) |=> irq);
endmodule

bind ring_irq_notify ring_irq_notify_chk #(
   .HOPS(HOPS), .NW(NOTE_WORDS), .ADDR_W(ADDR_W),
   .NOTIFY_BASE(NOTIFY_BASE), .HOPCNT_ADDR(HOPCNT_ADDR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ev_tx(ev_tx), .ev_rx(ev_rx), .ev_ovf(ev_ovf),
   .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_rdata(reg_rdata), .irq(irq),
   .note_pad(note_pad)
);

// File: tb/tb_ring_irq_notify.sv
module tb_ring_irq_notify;
   localparam int HOPS = 12;
   localparam int AW   = 4;
   localparam logic [AW-1:0] A_N0 = 4'd0, A_N1 = 4'd1, A_N2 = 4'd2,
                             A_EN = 4'd8, A_HC = 4'd12;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [HOPS-1:0] ev_tx = '0, ev_rx = '0, ev_ovf = '0;
   logic            reg_rd = 1'b0, reg_wr = 1'b0;
   logic [AW-1:0]   reg_addr = '0;
   logic [31:0]     reg_wdata = '0;
   logic [31:0]     reg_rdata;
   logic            irq;

   int n_vec = 0;
   int n_bad = 0;
   logic done = 1'b0;

   always #2.5 clk = ~clk;

   ring_irq_notify dut (
      .clk(clk), .rst_n(rst_n), .ev_tx(ev_tx), .ev_rx(ev_rx), .ev_ovf(ev_ovf),
      .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
      reg_rd = 1'b1; reg_addr = a;
      step();
      reg_rd = 1'b0;
      d = reg_rdata;
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      step();
      reg_wr = 1'b0;
   endtask

   task automatic pulse(input logic [HOPS-1:0] t, input logic [HOPS-1:0] r,
                        input logic [HOPS-1:0] o);
      ev_tx = t; ev_rx = r; ev_ovf = o;
      step();
      ev_tx = '0; ev_rx = '0; ev_ovf = '0;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      check("R10 irq after reset", {31'b0, irq}, 32'h0);
      rd(A_N0, d); check("R10 notify0 after reset", d, 32'h0);
      rd(A_N1, d); check("R10 notify1 after reset", d, 32'h0);
      rd(A_EN, d); check("R10 enable after reset", d, 32'h0);
   endtask

   task automatic t_hopcnt();
      logic [31:0] d;
      rd(A_HC, d); check("R6 hop count", d, 32'd12);
   endtask

   task automatic t_packing();
      logic [31:0] d;
      pulse(12'h008, 12'h020, 12'h201);
      check("R8 no irq with enables clear", {31'b0, irq}, 32'h0);
      rd(A_N0, d); check("R1 word0 packing", d, 32'h0102_0008);
      rd(A_N1, d); check("R1 word1 overflow straddle", d, 32'h0000_0002);
      rd(A_N0, d); check("R3 word0 cleared", d, 32'h0);
      pulse('0, '0, '1);
      rd(A_N1, d); check("R2 word1 padding zero", d, 32'h0000_000F);
      rd(A_N0, d); check("R1 word0 overflow bits", d, 32'hFF00_0000);
      rd(A_N2, d); check("R2 past last word", d, 32'h0);
   endtask

   task automatic t_enable();
      logic [31:0] d;
      wr(A_EN, 32'hFFFF_FFFF);
      rd(A_EN, d); check("R5 enable unused bits", d, 32'h00FF_FFFF);
      wr(A_EN, 32'h0000_0000);
      rd(A_EN, d); check("R5 enable cleared", d, 32'h0);
   endtask

   task automatic t_race();
      logic [31:0] d;
      ev_tx = 12'h002;
      rd(A_N0, d);
      ev_tx = '0;
      check("R4 read returns old value", d, 32'h0);
      rd(A_N0, d); check("R4 event kept after clear", d, 32'h0000_0002);
   endtask

   task automatic t_irq();
      logic [31:0] d;
      wr(A_EN, 32'h0000_0004);            // rx enable of hop 2 only
      pulse(12'h004, '0, '0);
      step();
      check("R8 tx bit with tx enable clear", {31'b0, irq}, 32'h0);
      rd(A_N0, d); rd(A_N1, d);
      pulse('0, '0, 12'h004);
      check("R7 irq not yet", {31'b0, irq}, 32'h0);
      step();
      check("R8 R7 overflow gated by rx enable", {31'b0, irq}, 32'h1);
      rd(A_N0, d); check("R1 overflow hop2 bit", d, 32'h0400_0000);
      check("R9 irq held after partial read", {31'b0, irq}, 32'h1);
      step();
      check("R9 irq held idle", {31'b0, irq}, 32'h1);
      rd(A_N1, d);
      check("R9 irq drops after last word", {31'b0, irq}, 32'h0);
      step();
      check("R9 stays low", {31'b0, irq}, 32'h0);
   endtask

   task automatic t_rearm();
      logic [31:0] d;
      wr(A_EN, 32'h0000_1000);            // tx enable of hop 0
      pulse(12'h001, '0, '0);
      step();
      check("R7 tx irq", {31'b0, irq}, 32'h1);
      rd(A_N0, d);
      pulse(12'h001, '0, '0);
      rd(A_N1, d);
      check("R11 irq drops on rearm", {31'b0, irq}, 32'h0);
      step();
      check("R11 irq refires", {31'b0, irq}, 32'h1);
      rd(A_N1, d); rd(A_N0, d);
      check("R11 bit seen", d, 32'h0000_0001);
      step();
      check("R9 low after full sweep", {31'b0, irq}, 32'h0);
   endtask

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      step();
      t_reset();
      t_hopcnt();
      t_packing();
      t_enable();
      t_race();
      t_irq();
      t_rearm();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_vec++; n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule